// File: doc/BRIEF.md
# Storage Row Sequencer

This block follows playback or recording through a row-organised sample store. It counts sample strobes across the current row. When a row is full it steps the row address on by one. Over the final block of each row it drives an active-low row-end line, given as an open-drain pull-down enable.

When a pass runs past the last row, the sequencer stops and holds the address there. It stops in the same way when an end-of-message marker arrives. Both conditions set a status bit and a sticky interrupt, which stays asserted until the interrupt-clear pulse.

A controller starts a pass by giving a start row and a start pulse, then feeds sample strobes at the sample rate. A stop pulse ends the pass quietly. The controller reads the row address, the row-end line and the status bits. Sample-rate timing and the store itself lie outside the block.

By default the store has 1888 rows of 2048 samples, and each row is cut into 64-sample blocks. All three sizes are parameters.

Top module: `row_sequencer`

## Requirements
- R1: After reset the sequencer is idle. `row_addr` is 0, `row_end_oe` is 0, `irq_n` is 1, and `ovf_flag` and `eom_flag` are 0.
- R2: A start pulse loads `start_row` into `row_addr`, sets the sample position to zero and puts the sequencer in the running state. This holds whether the sequencer was idle or running.
- R3: While running, each `sample_tick` moves the sample position on by one. On the tick that completes sample ROW_SAMPLES-1 the position returns to zero and `row_addr` rises by one. `row_addr` never changes in any other way except through a start pulse.
- R4: `row_end_oe` is 1 exactly when the sequencer is running and the sample position lies within the last BLOCK_SAMPLES positions of the row. It is 0 whenever the sequencer is idle.
- R5: A stop pulse while running makes the sequencer idle without touching `row_addr` or the status bits. While idle, `sample_tick`, `stop_pulse` and `eom_mark` have no effect on any output.
- R6: `eom_mark` while running makes the sequencer idle, sets `eom_flag` and pulls `irq_n` low.
- R7: The row wrap that would leave row ROWS-1 is an overflow. The sequencer goes idle, `row_addr` stays at ROWS-1, `ovf_flag` is set and `irq_n` goes low.
- R8: `irq_n` is low exactly while `ovf_flag` or `eom_flag` is set. Both bits stay set until an `irq_clear` pulse, which zeroes them. A condition that sets a bit in the same cycle as `irq_clear` wins for that bit.
- R9: When several controls arrive in one cycle, start wins over `eom_mark`, `eom_mark` wins over stop, and stop wins over `sample_tick`. Every control after the winner is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sample_tick | input | 1 | One-cycle strobe per sample |
| start_pulse | input | 1 | Begins a pass at `start_row` |
| stop_pulse | input | 1 | Ends a pass without an interrupt |
| start_row | input | ROW_W | Row loaded on start (must be below ROWS) |
| eom_mark | input | 1 | End-of-message marker seen in the data |
| irq_clear | input | 1 | Status-read pulse that clears the interrupt and status bits |
| row_addr | output | ROW_W | Current row |
| row_end_oe | output | 1 | 1 = pull the row-end line low (final block of the row) |
| irq_n | output | 1 | Active-low sticky interrupt |
| ovf_flag | output | 1 | Overflow status |
| eom_flag | output | 1 | End-of-message status |

## Verification
The bench builds the block with 5 rows, 16 samples per row and 4-sample blocks. With these sizes a pass starting at a random row overflows within a few dozen strobes, so random runs reach overflow, row wrap and the row-end window many times. Directed sequences cover the same-cycle clear-versus-set case and the control priority order, and they check that every control is ignored while idle. Because ROW_W is 3 and only 5 rows are used, the address field also has unused codes above the last row. This exposes any wrap past ROWS-1.

// File: rtl/rs_pkg.sv
package rs_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } rs_state_t;
endpackage

// File: rtl/rs_sample_ctr.sv
module rs_sample_ctr #(
  parameter int ROW_SAMPLES   = 2048,
  parameter int BLOCK_SAMPLES = 64,
  localparam int SMP_W        = $clog2(ROW_SAMPLES)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic adv,
  output logic at_last,
  output logic in_tail
);
  localparam logic [SMP_W-1:0] LAST_POS = SMP_W'(ROW_SAMPLES - 1);
  localparam logic [SMP_W-1:0] TAIL_POS = SMP_W'(ROW_SAMPLES - BLOCK_SAMPLES);

  logic [SMP_W-1:0] pos_q, pos_d;
  logic             pos_en;

  always_comb begin
    pos_en = clr | adv;
    pos_d  = pos_q;
    if (clr)             pos_d = '0;
    else if (pos_q == LAST_POS) pos_d = '0;
    else                 pos_d = pos_q + SMP_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pos_q <= '0;
    else if (pos_en) pos_q <= pos_d;
  end

  assign at_last = (pos_q == LAST_POS);
  assign in_tail = (pos_q >= TAIL_POS);
endmodule

// File: rtl/rs_row_ctr.sv
module rs_row_ctr #(
  parameter int ROWS   = 1888,
  localparam int ROW_W = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [ROW_W-1:0] load_val,
  input  logic             adv,
  output logic [ROW_W-1:0] row,
  output logic             at_last
);
  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);

  logic [ROW_W-1:0] row_q, row_d;
  logic             row_en;

  always_comb begin
    row_en = load | adv;
    if (load) row_d = load_val;
    else      row_d = row_q + ROW_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      row_q <= '0;
    else if (row_en) row_q <= row_d;
  end

  assign row     = row_q;
  assign at_last = (row_q == LAST_ROW);
endmodule

// File: rtl/rs_event_latch.sv
module rs_event_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic set_ovf,
  input  logic set_eom,
  output logic ovf,
  output logic eom
);
  logic ovf_q, ovf_d, eom_q, eom_d;

  always_comb begin
    ovf_d = ovf_q & ~clr;
    eom_d = eom_q & ~clr;
    if (set_ovf) ovf_d = 1'b1;
    if (set_eom) eom_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      eom_q <= 1'b0;
    end else begin
      ovf_q <= ovf_d;
      eom_q <= eom_d;
    end
  end

  assign ovf = ovf_q;
  assign eom = eom_q;
endmodule

// File: rtl/row_sequencer.sv
module row_sequencer #(
  parameter int ROWS          = 1888,
  parameter int ROW_SAMPLES   = 2048,
  parameter int BLOCK_SAMPLES = 64,
  localparam int ROW_W        = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_tick,
  input  logic             start_pulse,
  input  logic             stop_pulse,
  input  logic [ROW_W-1:0] start_row,
  input  logic             eom_mark,
  input  logic             irq_clear,
  output logic [ROW_W-1:0] row_addr,
  output logic             row_end_oe,
  output logic             irq_n,
  output logic             ovf_flag,
  output logic             eom_flag
);
  import rs_pkg::*;

  // reset: asserted at once, released on a clock edge
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  rs_state_t state_q, state_d;
  logic      run_q;
  logic      go_start, go_eom, go_stop, go_tick;
  logic      smp_last, smp_tail, row_last;
  logic      row_wrap, ovf_hit;

  assign run_q = (state_q == ST_RUN);

  // control priority: start > eom > stop > tick
  always_comb begin
    go_start = start_pulse;
    go_eom   = run_q & ~start_pulse & eom_mark;
    go_stop  = run_q & ~start_pulse & ~eom_mark & stop_pulse;
    go_tick  = run_q & ~start_pulse & ~eom_mark & ~stop_pulse & sample_tick;
    row_wrap = go_tick & smp_last;
    ovf_hit  = row_wrap & row_last;
  end

  always_comb begin
    state_d = state_q;
    if (go_start)                          state_d = ST_RUN;
    else if (go_eom | go_stop | ovf_hit)   state_d = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) state_q <= ST_IDLE;
    else             state_q <= state_d;
  end

  rs_sample_ctr #(
    .ROW_SAMPLES  (ROW_SAMPLES),
    .BLOCK_SAMPLES(BLOCK_SAMPLES)
  ) u_smp (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .clr    (go_start),
    .adv    (go_tick),
    .at_last(smp_last),
    .in_tail(smp_tail)
  );

  rs_row_ctr #(
    .ROWS(ROWS)
  ) u_row (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .load    (go_start),
    .load_val(start_row),
    .adv     (row_wrap & ~row_last),
    .row     (row_addr),
    .at_last (row_last)
  );

  rs_event_latch u_evt (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .clr    (irq_clear),
    .set_ovf(ovf_hit),
    .set_eom(go_eom),
    .ovf    (ovf_flag),
    .eom    (eom_flag)
  );

  assign row_end_oe = run_q & smp_tail;
  assign irq_n      = ~(ovf_flag | eom_flag);
endmodule

// File: rtl/row_sequencer_chk.sv
module row_sequencer_chk #(
  parameter int ROWS  = 1888,
  parameter int ROW_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_pulse,
  input logic             eom_mark,
  input logic             irq_clear,
  input logic             run_q,
  input logic [ROW_W-1:0] row_addr,
  input logic             row_end_oe,
  input logic             irq_n,
  input logic             eom_flag,
  input logic             ovf_flag
);
  // R4
  row_end_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> !row_end_oe);
  // R5
  idle_row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !start_pulse) |=> (row_addr == $past(row_addr)));
  // R3
  row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start_pulse |=> (row_addr == $past(row_addr) ||
                      row_addr == ROW_W'($past(row_addr) + ROW_W'(1))));
  // R6
  eom_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && eom_mark && !start_pulse) |=> (eom_flag && !irq_n && !run_q));
  // R7
  ovf_at_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> (row_addr == ROW_W'(ROWS - 1) && !run_q));
  // R8
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_n && !irq_clear) |=> !irq_n);
  // R8
  irq_clear_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clear && !run_q) |=> irq_n);
endmodule

bind row_sequencer row_sequencer_chk #(
  .ROWS (ROWS),
  .ROW_W(ROW_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .start_pulse(start_pulse),
  .eom_mark   (eom_mark),
  .irq_clear  (irq_clear),
  .run_q      (run_q),
  .row_addr   (row_addr),
  .row_end_oe (row_end_oe),
  .irq_n      (irq_n),
  .eom_flag   (eom_flag),
  .ovf_flag   (ovf_flag)
);

// File: tb/row_sequencer_tb.sv
`timescale 1ns/1ps
module row_sequencer_tb;
  localparam int ROWS = 5;
  localparam int SPR  = 16;
  localparam int BLK  = 4;
  localparam int RW   = $clog2(ROWS);

  logic clk = 1'b0;
  logic rst_n;
  logic sample_tick, start_pulse, stop_pulse, eom_mark, irq_clear;
  logic [RW-1:0] start_row, row_addr;
  logic row_end_oe, irq_n, ovf_flag, eom_flag;

  int checks = 0;
  int errors = 0;
  int cyc_cnt = 0;

  // reference state
  bit m_run, m_ovf, m_eom;
  int m_row, m_smp;

  always #2.5 clk = ~clk;

  row_sequencer #(.ROWS(ROWS), .ROW_SAMPLES(SPR), .BLOCK_SAMPLES(BLK)) u_dut (
    .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .start_pulse(start_pulse),
    .stop_pulse(stop_pulse), .start_row(start_row), .eom_mark(eom_mark),
    .irq_clear(irq_clear), .row_addr(row_addr), .row_end_oe(row_end_oe),
    .irq_n(irq_n), .ovf_flag(ovf_flag), .eom_flag(eom_flag));

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt == 100000) begin
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic bit exp_row_end();
    return m_run && (m_smp >= SPR - BLK);
  endfunction

  task automatic compare_all();
    chk("R3 row_addr", int'(row_addr), m_row);
    chk("R4 row_end_oe", int'(row_end_oe), int'(exp_row_end()));
    chk("R7 ovf_flag", int'(ovf_flag), int'(m_ovf));
    chk("R6 eom_flag", int'(eom_flag), int'(m_eom));
    chk("R8 irq_n", int'(irq_n), int'(!(m_ovf || m_eom)));
  endtask

  task automatic model_step(input bit st, input bit sp, input bit em, input bit tk,
                            input bit cl, input int srow);
    bit set_o = 0, set_e = 0;
    if (st) begin
      m_run = 1; m_row = srow; m_smp = 0;
    end else if (m_run) begin
      if (em) begin m_run = 0; set_e = 1; end
      else if (sp) m_run = 0;
      else if (tk) begin
        if (m_smp == SPR - 1) begin
          m_smp = 0;
          if (m_row == ROWS - 1) begin m_run = 0; set_o = 1; end
          else m_row++;
        end else m_smp++;
      end
    end
    if (cl) begin m_ovf = 0; m_eom = 0; end
    if (set_o) m_ovf = 1;
    if (set_e) m_eom = 1;
  endtask

  // drive after a falling edge, compare at the next falling edge
  task automatic cyc(input bit st, input bit sp, input bit em, input bit tk,
                     input bit cl, input int srow);
    start_pulse = st; stop_pulse = sp; eom_mark = em; sample_tick = tk;
    irq_clear = cl; start_row = RW'(srow);
    model_step(st, sp, em, tk, cl, srow);
    @(negedge clk);
    compare_all();
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 1, 0, 0);
  endtask

  initial begin
    void'($urandom(32'h5EC0_0D11));
    rst_n = 1'b0;
    {sample_tick, start_pulse, stop_pulse, eom_mark, irq_clear} = '0;
    start_row = '0;
    m_run = 0; m_ovf = 0; m_eom = 0; m_row = 0; m_smp = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 row_addr", int'(row_addr), 0);
    chk("R1 row_end_oe", int'(row_end_oe), 0);
    chk("R1 irq_n", int'(irq_n), 1);
    chk("R1 flags", int'({ovf_flag, eom_flag}), 0);

    // R2 start load, R4 tail window timing
    cyc(1, 0, 0, 0, 0, 3);
    chk("R2 start_row load", int'(row_addr), 3);
    ticks(SPR - BLK - 1);
    chk("R4 before tail", int'(row_end_oe), 0);
    ticks(1);
    chk("R4 tail entered", int'(row_end_oe), 1);
    ticks(BLK);
    chk("R3 row stepped", int'(row_addr), 4);
    chk("R4 tail left", int'(row_end_oe), 0);

    // R5 stop, then ignored controls while idle
    ticks(SPR - 1);
    cyc(0, 1, 0, 0, 0, 0);
    ticks(5);
    cyc(0, 1, 1, 1, 0, 0);
    chk("R5 idle row held", int'(row_addr), 4);
    chk("R5 no irq on stop", int'(irq_n), 1);
    chk("R5 idle row_end", int'(row_end_oe), 0);

    // R7 overflow from the last row
    cyc(1, 0, 0, 0, 0, ROWS - 1);
    ticks(SPR);
    chk("R7 ovf set", int'(ovf_flag), 1);
    chk("R7 row held at last", int'(row_addr), ROWS - 1);
    ticks(3);
    chk("R7 halted", int'(row_addr), ROWS - 1);

    // R8 clear racing a new end-of-message
    cyc(1, 0, 0, 0, 0, 0);
    cyc(0, 0, 1, 0, 1, 0);
    chk("R8 set wins eom", int'(eom_flag), 1);
    chk("R8 clear ovf", int'(ovf_flag), 0);
    chk("R8 irq low", int'(irq_n), 0);
    cyc(0, 0, 0, 0, 1, 0);
    chk("R8 irq released", int'(irq_n), 1);

    // R9 priorities
    cyc(1, 0, 0, 0, 0, 1);
    ticks(2);
    cyc(1, 1, 1, 1, 0, 2);
    chk("R9 start beats eom", int'(eom_flag), 0);
    chk("R9 start reload", int'(row_addr), 2);
    cyc(0, 1, 1, 0, 0, 0);
    chk("R9 eom beats stop", int'(eom_flag), 1);
    cyc(0, 0, 0, 0, 1, 0);
    cyc(1, 0, 0, 0, 0, 0);
    ticks(SPR - 1);
    cyc(0, 1, 0, 1, 0, 0);
    chk("R9 stop beats tick", int'(row_addr), 0);

    // R6 eom while idle ignored
    cyc(0, 0, 1, 0, 0, 0);
    chk("R6 idle eom ignored", int'(eom_flag), 0);

    // constrained random
    for (int n = 0; n < 4000; n++) begin
      bit st, sp, em, tk, cl;
      st = ($urandom % 40) == 0;
      sp = ($urandom % 64) == 0;
      em = ($urandom % 64) == 0;
      tk = ($urandom % 2) == 0;
      cl = ($urandom % 16) == 0;
      cyc(st, sp, em, tk, cl, int'($urandom % ROWS));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule